// File: doc/BRIEF.md
# Two-Axis Sensor Register Target on an I2C Bus

This block is the serial front end of a two-axis motion sensor. It sits on an I2C bus as a target. It holds one writable control register and a small read-only window of sensor bytes. The bus lines arrive as raw pad levels and are oversampled on the system clock. The target answers only to its own 7-bit address. The upper four bits of that address are fixed, and the lower three come from a strap.

In a write transaction, the master first sends a pointer byte and then a control byte. In a read transaction, the master streams bytes from the pointer onward, and the pointer advances after each byte. When the temperature-enable bit is set, the temperature reading replaces the X reading in the window. The three control bits that matter drive the power-down, bandgap-test and temperature-enable outputs. The sensor samples are frozen into a shadow copy when a read is addressed. This keeps the high and low bytes of one axis from the same sample.

Top module: `snsr_i2c_target`

## Requirements
- R1: The target acknowledges only the address byte whose upper seven bits equal `0010` followed by `addr_strap`. Bit 0 of that byte selects read (1) or write (0). Any other address is left unacknowledged, and the transaction that follows it changes nothing.
- R2: After a matched address byte and after every byte written to it, the target pulls SDA low for the ninth SCL clock. It changes its SDA drive only while SCL is low.
- R3: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A START at any point, including mid-byte, restarts address reception. A STOP releases SDA and returns the target to idle.
- R4: In a write, the first byte after the address sets the pointer, using its low 3 bits. Data bytes after it update the control register only when the pointer is 0. At any other pointer they are acknowledged and discarded.
- R5: The control register keeps bits 3:0 and reads back bits 7:4 as zero. Bit 0 drives `pwr_down`, bit 2 drives `bg_test` and bit 3 drives `temp_en`. Bit 1 is stored but drives no output.
- R6: The read positions are 0 = control register, 1 = X high byte, 2 = X low byte, 3 = Y high byte and 4 = Y low byte. With `temp_en` set, positions 1 and 2 return the temperature value instead of X.
- R7: Each 12-bit sample is right-justified in a 16-bit word. The high byte carries sample bits 11:8 in bits 3:0, and its upper four bits read as zero.
- R8: The pointer advances after every byte read. Positions 5, 6 and 7 read 0x00. The position after 6 is 0.
- R9: Read bytes go out MSB first. The next byte follows only if the master acknowledged. After a NACK the target keeps SDA released until the next START or STOP.
- R10: The X, Y and temperature inputs are copied into a shadow when a read address is matched. Every byte of that read comes from the copy.
- R11: After reset the control register is 0x00, all three control outputs are low and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL pad level |
| sda_i | input | 1 | Raw SDA pad level |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_strap | input | 3 | Low three bits of the 7-bit target address |
| x_val | input | DATA_W | X-axis sample |
| y_val | input | DATA_W | Y-axis sample |
| t_val | input | DATA_W | Temperature sample |
| pwr_down | output | 1 | Control bit 0 |
| bg_test | output | 1 | Control bit 2 |
| temp_en | output | 1 | Control bit 3, selects temperature in the X positions |

## Verification
The bench uses the default parameters: 12-bit samples, a two-stage synchroniser, a 3-bit pointer and wrap after position 6. The address strap is tied to 3'b101, so the target answers at 0x2A for writes and 0x2B for reads. The bus runs at 24 system clocks per bit, which leaves several cycles of margin after each synchronised SCL edge. With a 3-bit pointer and wrap after position 6, a single eight-byte read from position 0 passes both zero positions and reaches the wrap. Samples are changed in the middle of a read to expose the shadow copy.

// File: rtl/snsr_i2c_pkg.sv
package snsr_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_WAIT
  } st_e;

  typedef enum logic [1:0] {
    RX_ADDR, RX_PTR, RX_DATA
  } rxk_e;

  localparam int CTRL_W  = 4;
  localparam int CTRL_PD = 0;
  localparam int CTRL_BG = 2;
  localparam int CTRL_TE = 3;
endpackage

// File: rtl/snsr_bus_sync.sv
module snsr_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/snsr_regmap.sv
module snsr_regmap
  import snsr_i2c_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] x_val,
  input  logic [DATA_W-1:0] y_val,
  input  logic [DATA_W-1:0] t_val,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [7:0]        rd_byte,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam int WORD_W = 16;

  logic [DATA_W-1:0] x_sh, y_sh, t_sh;
  logic [WORD_W-1:0] a_word, y_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      x_sh   <= '0;
      y_sh   <= '0;
      t_sh   <= '0;
    end else begin
      if (wr_en)  ctrl_q <= ctrl_wdata;
      if (cap_en) begin
        x_sh <= x_val;
        y_sh <= y_val;
        t_sh <= t_val;
      end
    end
  end

  always_comb begin
    a_word = '0;
    y_word = '0;
    a_word[DATA_W-1:0] = ctrl_q[CTRL_TE] ? t_sh : x_sh;
    y_word[DATA_W-1:0] = y_sh;
    case (rd_ptr)
      PTR_W'(0): rd_byte = {{(8-CTRL_W){1'b0}}, ctrl_q};
      PTR_W'(1): rd_byte = a_word[15:8];
      PTR_W'(2): rd_byte = a_word[7:0];
      PTR_W'(3): rd_byte = y_word[15:8];
      PTR_W'(4): rd_byte = y_word[7:0];
      default:   rd_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/snsr_i2c_target.sv
module snsr_i2c_target
  import snsr_i2c_pkg::*;
#(
  parameter int         DATA_W      = 12,
  parameter int         SYNC_STAGES = 2,
  parameter int         PTR_W       = 3,
  parameter int         WRAP_POS    = 6,
  parameter logic [3:0] ADDR_HI     = 4'b0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        addr_strap,
  input  logic [DATA_W-1:0] x_val,
  input  logic [DATA_W-1:0] y_val,
  input  logic [DATA_W-1:0] t_val,
  output logic              pwr_down,
  output logic              bg_test,
  output logic              temp_en
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(WRAP_POS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, cap_en, rd_mode, mack;
  logic [3:0] bcnt;
  logic [7:0] sh;
  logic [6:0] tx;
  logic [PTR_W-1:0] ptr, ptr_nxt;
  logic [7:0] rd_byte;
  logic [CTRL_W-1:0] ctrl_q;
  st_e  state;
  rxk_e kind;

  snsr_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  snsr_regmap #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ctrl_wdata(sh[CTRL_W-1:0]),
    .cap_en(cap_en), .x_val(x_val), .y_val(y_val), .t_val(t_val),
    .rd_ptr(ptr), .rd_byte(rd_byte), .ctrl_q(ctrl_q)
  );

  assign ptr_nxt = (ptr == LAST_PTR) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      kind    <= RX_ADDR;
      bcnt    <= '0;
      sh      <= '0;
      tx      <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      cap_en  <= 1'b0;
      rd_mode <= 1'b0;
      mack    <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      cap_en <= 1'b0;
      if (start_det) begin
        state  <= ST_RX;
        kind   <= RX_ADDR;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bcnt < 4'd8) begin
              sh   <= {sh[6:0], sda_s};
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              bcnt <= '0;
              case (kind)
                RX_ADDR: begin
                  if (sh[7:1] == {ADDR_HI, addr_strap}) begin
                    sda_oe  <= 1'b1;
                    state   <= ST_RX_ACK;
                    rd_mode <= sh[0];
                    cap_en  <= sh[0];
                  end else begin
                    state <= ST_WAIT;
                  end
                end
                RX_PTR: begin
                  ptr    <= sh[PTR_W-1:0];
                  sda_oe <= 1'b1;
                  state  <= ST_RX_ACK;
                end
                default: begin
                  wr_en  <= (ptr == '0);
                  sda_oe <= 1'b1;
                  state  <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bcnt <= '0;
              if (kind == RX_ADDR && rd_mode) begin
                tx     <= rd_byte[6:0];
                sda_oe <= ~rd_byte[7];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
                kind   <= (kind == RX_ADDR) ? RX_PTR : RX_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bcnt == 4'd7) begin
                sda_oe <= 1'b0;
                ptr    <= ptr_nxt;
                state  <= ST_TX_ACK;
              end else begin
                bcnt   <= bcnt + 4'd1;
                tx     <= {tx[5:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              bcnt <= '0;
              if (mack) begin
                tx     <= rd_byte[6:0];
                sda_oe <= ~rd_byte[7];
                state  <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pwr_down = ctrl_q[CTRL_PD];
  assign bg_test  = ctrl_q[CTRL_BG];
  assign temp_en  = ctrl_q[CTRL_TE];
endmodule

// File: rtl/snsr_i2c_chk.sv
module snsr_i2c_chk
  import snsr_i2c_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_oe,
  input logic             stop_det,
  input logic             scl_s,
  input logic             wr_en,
  input logic [2:0]       state,
  input logic [PTR_W-1:0] ptr,
  input logic             pwr_down,
  input logic             bg_test,
  input logic             temp_en
);
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe); // R3

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s)); // R2

  AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    ({pwr_down, bg_test, temp_en} != $past({pwr_down, bg_test, temp_en})) |-> $past(wr_en)); // R4

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == 3'(ST_TX) && state == 3'(ST_TX_ACK) && $past(ptr) == PTR_W'(6)) |-> ptr == '0); // R8

  AST_NACK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == 3'(ST_WAIT)) |-> !sda_oe); // R9

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!pwr_down && !bg_test && !temp_en && !sda_oe)); // R11
endmodule

bind snsr_i2c_target snsr_i2c_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .stop_det(stop_det), .scl_s(scl_s),
  .wr_en(wr_en), .state(state), .ptr(ptr), .pwr_down(pwr_down),
  .bg_test(bg_test), .temp_en(temp_en)
);

// File: tb/snsr_i2c_target_tb.sv
module snsr_i2c_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] ADDR_W = {4'b0010, STRAP, 1'b0};
  localparam logic [7:0] ADDR_R = {4'b0010, STRAP, 1'b1};

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [7:0]  ptr;
    logic [11:0] x;
    logic [11:0] y;
    logic [11:0] t;
    logic [7:0]  e0;
    logic [7:0]  e1;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'h00, 8'h01, 12'hABC, 12'h123, 12'h456, 8'h0A, 8'hBC},
    '{8'h08, 8'h01, 12'hABC, 12'h123, 12'h456, 8'h04, 8'h56},
    '{8'h00, 8'h03, 12'hABC, 12'h7F1, 12'h456, 8'h07, 8'hF1},
    '{8'h04, 8'h00, 12'h3E5, 12'h7F1, 12'h456, 8'h04, 8'h03},
    '{8'h08, 8'h04, 12'h3E5, 12'h9A5, 12'h456, 8'hA5, 8'h00},
    '{8'h04, 8'h06, 12'h3E5, 12'h9A5, 12'h456, 8'h00, 8'h04},
    '{8'h0D, 8'h02, 12'h111, 12'h123, 12'hFED, 8'hED, 8'h01}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, pwr_down, bg_test, temp_en;
  logic [11:0] x_val = '0, y_val = '0, t_val = '0;
  logic sda_bus;
  logic smp;
  logic ack;
  logic [7:0] rbuf [8];
  logic [7:0] b;
  int n_chk = 0, n_fail = 0;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  snsr_i2c_target u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_strap(STRAP), .x_val(x_val), .y_val(y_val), .t_val(t_val),
    .pwr_down(pwr_down), .bg_test(bg_test), .temp_en(temp_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; w(); scl_m = 1'b1; w(); sda_m = 1'b0; w(); scl_m = 1'b0; w();
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w(); scl_m = 1'b1; w(); sda_m = 1'b1; w();
  endtask

  task automatic bit_cyc(input logic v);
    sda_m = v; w(); scl_m = 1'b1; w(); smp = sda_bus; w(); scl_m = 1'b0; w();
  endtask

  task automatic wbyte(input logic [7:0] v, output logic a);
    for (int i = 7; i >= 0; i--) bit_cyc(v[i]);
    bit_cyc(1'b1);
    a = ~smp;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      bit_cyc(1'b1);
      v[i] = smp;
    end
    bit_cyc(~give_ack);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    logic a;
    bus_start();
    wbyte(ADDR_W, a); chk("R1 write address ack", a, 1'b1);
    wbyte(8'h00, a);  chk("R2 pointer byte ack", a, 1'b1);
    wbyte(v, a);      chk("R2 control byte ack", a, 1'b1);
    bus_stop();
  endtask

  task automatic read_from(input logic [7:0] p, input int n);
    logic a;
    bus_start();
    wbyte(ADDR_W, a); chk("R1 address ack", a, 1'b1);
    wbyte(p, a);      chk("R2 pointer ack", a, 1'b1);
    bus_start();
    wbyte(ADDR_R, a); chk("R1 read address ack", a, 1'b1);
    for (int i = 0; i < n; i++) rbyte(i < n - 1, rbuf[i]);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 sda released", sda_oe, 1'b0);
    chk("R11 control outputs", {pwr_down, bg_test, temp_en}, 3'b000);
    read_from(8'h00, 1);
    chk("R11 control reads zero", rbuf[0], 8'h00);

    // table walk: R6 R7 R8
    foreach (VECS[k]) begin
      x_val = VECS[k].x; y_val = VECS[k].y; t_val = VECS[k].t;
      wr_ctrl(VECS[k].ctrl);
      read_from(VECS[k].ptr, 2);
      chk("R6 R7 R8 first byte", rbuf[0], VECS[k].e0);
      chk("R6 R7 R8 second byte", rbuf[1], VECS[k].e1);
    end
    chk("R5 outputs after 0x0D", {pwr_down, bg_test, temp_en}, 3'b111);

    // R5 upper bits dropped, reserved bit kept
    wr_ctrl(8'hFA);
    chk("R5 outputs after 0xFA", {pwr_down, bg_test, temp_en}, 3'b001);
    read_from(8'h00, 1);
    chk("R5 control readback", rbuf[0], 8'h0A);
    wr_ctrl(8'h05);
    chk("R5 outputs after 0x05", {pwr_down, bg_test, temp_en}, 3'b110);
    wr_ctrl(8'h00);

    // R1 foreign address ignored
    bus_start();
    wbyte(8'h2C, ack); chk("R1 foreign address nack", ack, 1'b0);
    wbyte(8'h00, ack); chk("R1 no ack after foreign", ack, 1'b0);
    wbyte(8'h01, ack); chk("R1 no ack after foreign data", ack, 1'b0);
    bus_stop();
    chk("R1 foreign write ignored", pwr_down, 1'b0);
    bus_start();
    wbyte(8'h00, ack); chk("R1 general call nack", ack, 1'b0);
    bus_stop();

    // R4 write at nonzero pointer discarded
    bus_start();
    wbyte(ADDR_W, ack); chk("R4 address ack", ack, 1'b1);
    wbyte(8'h02, ack);  chk("R4 pointer ack", ack, 1'b1);
    wbyte(8'h09, ack);  chk("R4 data ack at ptr 2", ack, 1'b1);
    bus_stop();
    chk("R4 outputs unchanged", {pwr_down, bg_test, temp_en}, 3'b000);
    read_from(8'h00, 1);
    chk("R4 control unchanged", rbuf[0], 8'h00);

    // R10 shadow keeps sample during read
    x_val = 12'h5A7;
    bus_start();
    wbyte(ADDR_W, ack); wbyte(8'h01, ack);
    bus_start();
    wbyte(ADDR_R, ack);
    rbyte(1'b1, b); chk("R10 X high byte", b, 8'h05);
    x_val = 12'hFFF;
    rbyte(1'b0, b); chk("R10 X low byte from shadow", b, 8'hA7);
    bus_stop();
    read_from(8'h01, 1);
    chk("R10 new sample on next read", rbuf[0], 8'h0F);

    // R8 full stream with wrap
    wr_ctrl(8'h04);
    x_val = 12'h123; y_val = 12'h456;
    read_from(8'h00, 8);
    chk("R8 pos0", rbuf[0], 8'h04);
    chk("R8 pos1", rbuf[1], 8'h01);
    chk("R8 pos2", rbuf[2], 8'h23);
    chk("R8 pos3", rbuf[3], 8'h04);
    chk("R8 pos4", rbuf[4], 8'h56);
    chk("R8 pos5", rbuf[5], 8'h00);
    chk("R8 pos6", rbuf[6], 8'h00);
    chk("R8 wrap to pos0", rbuf[7], 8'h04);

    // R9 after nack the bus stays released
    bus_start();
    wbyte(ADDR_W, ack); wbyte(8'h01, ack);
    bus_start();
    wbyte(ADDR_R, ack);
    rbyte(1'b0, b); chk("R9 byte before nack", b, 8'h01);
    rbyte(1'b0, b); chk("R9 released after nack", b, 8'hFF);
    chk("R9 sda not driven", sda_oe, 1'b0);
    bus_stop();

    // R3 START mid-byte restarts, STOP releases
    bus_start();
    wbyte(ADDR_W, ack);
    bit_cyc(1'b0); bit_cyc(1'b1); bit_cyc(1'b0);
    wr_ctrl(8'h08);
    chk("R3 restart mid-byte then write", temp_en, 1'b1);
    bus_start();
    wbyte(ADDR_W, ack);
    bus_stop();
    chk("R3 stop releases sda", sda_oe, 1'b0);
    read_from(8'h00, 1);
    chk("R3 target usable after stop", rbuf[0], 8'h08);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule